// File: doc/BRIEF.md
# PAE Three-Level Page Table Walker

This block turns a 32-bit linear address into a physical page frame using the three-level scheme that extends physical addressing beyond 32 bits. The top level of the hierarchy is not fetched from memory. Four 64-bit pointer entries arrive already loaded on an input bus, together with a flag that says whether they are valid. Linear bits 31:30 choose one of the four. The walker then fetches the 8-byte directory entry and, for a 4 KB page, the 8-byte table entry through a simple request/acknowledge memory port.

When a walk succeeds the block reports a 40-bit frame number (physical bits 51:12), a page offset mask and the merged permission bits. When a walk fails it reports a page fault with an error code, or a general-protection fault if the pointer cache is not valid. A successful walk writes the accessed flag back to entries that lack it, and also the dirty flag to the leaf on a write. A new walk starts with a one-cycle `reqValid` pulse while the walker is idle. Each walk ends with a one-cycle `done` pulse that carries the result.

Top module: `pae_walker`

## Requirements
- R1: If `ptrCacheValid` is low when a request is taken, the walk ends with `gpFault`=1 and `pageFault`=0, and no memory access is made.
- R2: The pointer entry is `ptrCache[64*s +: 64]`, where s = linear bits 31:30. If that entry has bit 0 clear, the walk ends with `pageFault`=1, `pfErr`=3'b000, and no memory access is made.
- R3: The directory entry is read at physical address {pointer[51:12], lin[29:21], 3'b000}. For a 4 KB page the table entry is read at {dir[51:12], lin[20:12], 3'b000}, `frame` = table[51:12] and `pageMask` = 0xFFF.
- R4: A present directory entry with bit 7 set is a 2 MB leaf, whatever any size-enable setting says. Then `frame` = {dir[51:21], lin[20:12]}, `pageMask` = 0x1FFFFF, and no table entry is read.
- R5: A 2 MB directory entry with any of bits 20:13 set faults with `pfErr`=3'b011 (bit 0 = protection, bit 1 = reserved bit). No write-back follows.
- R6: A directory or table entry with bit 0 clear faults with `pfErr`=3'b000. No write-back follows.
- R7: On success, `combAccess` bit 1 (write allowed) and bit 2 (user allowed) are the AND of those bits over the directory entry and the table entry. For a 2 MB page only the directory entry counts. `combAccess` bit 8 is the leaf's bit 8 when `pgeEnable` is 1 and is 0 otherwise. All other bits are 0.
- R8: On success with a 4 KB page, a directory entry with bit 5 clear is written back with bit 5 set. The leaf is written back as leaf|0x20|(W<<6) when its bit 5 is clear, or when W=1 and its bit 6 is clear. W is `reqAcc` bit 0, which covers plain writes and read-modify-write. The directory write comes before the leaf write.
- R9: When `nxEnable` is 1 and bit 63 is set in the directory entry or the table entry, an instruction fetch (`reqAcc` bit 1) faults with `pfErr`=3'b101 (bit 2 = fetch) and no write-back. Bit 63 has no effect on non-fetch requests, and it has no effect at all when `nxEnable` is 0.
- R10: `done` is high for exactly one cycle per walk. `reqValid` is ignored while a walk is in progress. `memReq`, `memWrite` and `memAddr` stay stable until `memAck` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Start pulse for a walk (taken only when idle) |
| reqLinAddr | input | 32 | Linear address to translate |
| reqAcc | input | 2 | Bit 0 write or read-modify-write, bit 1 instruction fetch |
| ptrCacheValid | input | 1 | The four pointer entries are valid |
| ptrCache | input | 256 | Four 64-bit pointer entries, slot s at bits 64*s+63:64*s |
| pgeEnable | input | 1 | Global-page enable; passes leaf bit 8 to the output |
| nxEnable | input | 1 | Execute-disable enable |
| memReq | output | 1 | Memory access request, held until acknowledged |
| memWrite | output | 1 | Request is a write-back |
| memAddr | output | 52 | Physical byte address of the 8-byte entry |
| memWdata | output | 64 | Write-back data |
| memAck | input | 1 | Memory access done; read data valid |
| memRdata | input | 64 | Read data |
| done | output | 1 | One-cycle result strobe |
| pageFault | output | 1 | Walk ended in a page fault |
| gpFault | output | 1 | Walk ended in a general-protection fault |
| pfErr | output | 3 | Page fault code: bit 0 protection, bit 1 reserved, bit 2 fetch |
| frame | output | 40 | Physical frame, address bits 51:12 |
| pageMask | output | 21 | Page offset mask (0xFFF or 0x1FFFFF) |
| combAccess | output | 9 | Merged permissions: bit 1 write, bit 2 user, bit 8 global |

## Verification
The walk is driven with directory and table entries that differ in one respect at a time. Some have the accessed and dirty flags clear and some have them set, which separates a needed write-back from one that should not happen. Permission bits are varied per level, so an AND shows up as different from an OR or from a single level. The global bit is presented with the enable both on and off. Large-page entries are given clean and dirty reserved fields. The execute-disable bit is set on each level and crossed with fetch versus read and with the enable on and off. Other stimulus selects different pointer slots, sets frame bits up to bit 51 with high-order junk above them, and covers the invalid cache, absent entries at each level, and a request sent in the middle of a walk.

// File: rtl/pae_walk_pkg.sv
package pae_walk_pkg;

  typedef enum logic [1:0] {
    SEL_DIR_RD  = 2'd0,
    SEL_TBL_RD  = 2'd1,
    SEL_DIR_WB  = 2'd2,
    SEL_LEAF_WB = 2'd3
  } memSel_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PTR, ST_RD_DIR, ST_RD_TBL, ST_CHECK, ST_WB_DIR, ST_WB_LEAF
  } walkState_e;

  // Control -> datapath strobes
  typedef struct packed {
    logic    latchReq;
    logic    capDir;
    logic    capTbl;
    logic    finOk;
    logic    finPf;
    logic    finGp;
    logic [2:0] pfCode;
    memSel_e memSel;
  } walkCtl_t;

  // Datapath -> control status
  typedef struct packed {
    logic cacheOk;
    logic ptrPresent;
    logic rdPresent;
    logic rdLarge;
    logic rdRsvd;
    logic rdNx;
    logic nxSeen;
    logic isLarge;
    logic isFetch;
    logic dirNeedsA;
    logic leafNeedsUpd;
  } walkSts_t;

  localparam logic [2:0] PF_NOT_PRESENT = 3'b000;
  localparam logic [2:0] PF_RESERVED    = 3'b011;
  localparam logic [2:0] PF_EXEC        = 3'b101;

endpackage

// File: rtl/pae_walk_dpath.sv
module pae_walk_dpath
  import pae_walk_pkg::*;
#(
  parameter int LIN_W  = 32,
  parameter int PHYS_W = 52,
  parameter int ENT_W  = 64,
  parameter int SLOTS  = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  walkCtl_t                 ctl,
  input  logic [LIN_W-1:0]         reqLinAddr,
  input  logic [1:0]               reqAcc,
  input  logic                     ptrCacheValid,
  input  logic [SLOTS*ENT_W-1:0]   ptrCache,
  input  logic                     pgeEnable,
  input  logic                     nxEnable,
  input  logic [ENT_W-1:0]         memRdata,
  output walkSts_t                 sts,
  output logic [PHYS_W-1:0]        memAddr,
  output logic [ENT_W-1:0]         memWdata,
  output logic                     done,
  output logic                     pageFault,
  output logic                     gpFault,
  output logic [2:0]               pfErr,
  output logic [PHYS_W-13:0]       frame,
  output logic [20:0]              pageMask,
  output logic [8:0]               combAccess
);
  localparam int SLOT_W   = $clog2(SLOTS);
  localparam int FRAME_W  = PHYS_W - 12;
  localparam int IDX_W    = 9;
  localparam int BIG_W    = PHYS_W - 21;
  localparam logic [20:0] MASK_4K = 21'h000FFF;
  localparam logic [20:0] MASK_2M = 21'h1FFFFF;

  logic [ENT_W-1:0] slotEnt [SLOTS];
  for (genvar g = 0; g < SLOTS; g++) begin : gSlot
    assign slotEnt[g] = ptrCache[g*ENT_W +: ENT_W];
  end

  logic [LIN_W-1:0] linAddr;
  logic [1:0]       accReg;
  logic [ENT_W-1:0] ptrEnt, dirEnt, tblEnt;
  logic             cacheOk, isLarge, nxSeen;

  logic [IDX_W-1:0]  dirIdx, tblIdx;
  logic [PHYS_W-1:0] dirAddr, tblAddr;
  logic [ENT_W-1:0]  leafEnt;
  logic              isWrite;

  assign dirIdx  = linAddr[29:21];
  assign tblIdx  = linAddr[20:12];
  assign dirAddr = {ptrEnt[PHYS_W-1:12], dirIdx, 3'b000};
  assign tblAddr = {dirEnt[PHYS_W-1:12], tblIdx, 3'b000};
  assign leafEnt = isLarge ? dirEnt : tblEnt;
  assign isWrite = accReg[0];

  always_comb begin
    sts.cacheOk      = cacheOk;
    sts.ptrPresent   = ptrEnt[0];
    sts.rdPresent    = memRdata[0];
    sts.rdLarge      = memRdata[7];
    sts.rdRsvd       = |memRdata[20:13];
    sts.rdNx         = nxEnable & memRdata[ENT_W-1];
    sts.nxSeen       = nxSeen;
    sts.isLarge      = isLarge;
    sts.isFetch      = accReg[1];
    sts.dirNeedsA    = ~dirEnt[5];
    sts.leafNeedsUpd = ~leafEnt[5] | (isWrite & ~leafEnt[6]);
  end

  always_comb begin
    memAddr  = dirAddr;
    memWdata = '0;
    unique case (ctl.memSel)
      SEL_DIR_RD:  memAddr = dirAddr;
      SEL_TBL_RD:  memAddr = tblAddr;
      SEL_DIR_WB: begin
        memAddr  = dirAddr;
        memWdata = dirEnt | ENT_W'(64'h20);
      end
      SEL_LEAF_WB: begin
        memAddr  = isLarge ? dirAddr : tblAddr;
        memWdata = leafEnt | ENT_W'(64'h20) | (ENT_W'(isWrite) << 6);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      linAddr <= '0;
      accReg  <= '0;
      ptrEnt  <= '0;
      cacheOk <= 1'b0;
      dirEnt  <= '0;
      tblEnt  <= '0;
      isLarge <= 1'b0;
      nxSeen  <= 1'b0;
    end else begin
      if (ctl.latchReq) begin
        linAddr <= reqLinAddr;
        accReg  <= reqAcc;
        ptrEnt  <= slotEnt[reqLinAddr[LIN_W-1 -: SLOT_W]];
        cacheOk <= ptrCacheValid;
        nxSeen  <= 1'b0;
        isLarge <= 1'b0;
      end
      if (ctl.capDir) begin
        dirEnt  <= memRdata;
        isLarge <= memRdata[7];
        if (sts.rdNx) nxSeen <= 1'b1;
      end
      if (ctl.capTbl) begin
        tblEnt <= memRdata;
        if (sts.rdNx) nxSeen <= 1'b1;
      end
    end
  end

  logic [1:0]         permAnd;
  logic [FRAME_W-1:0] okFrame;
  assign permAnd = isLarge ? dirEnt[2:1] : (dirEnt[2:1] & tblEnt[2:1]);
  assign okFrame = isLarge ? {dirEnt[PHYS_W-1:21], tblIdx}
                           : tblEnt[PHYS_W-1:12];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      done       <= 1'b0;
      pageFault  <= 1'b0;
      gpFault    <= 1'b0;
      pfErr      <= '0;
      frame      <= '0;
      pageMask   <= '0;
      combAccess <= '0;
    end else begin
      done      <= ctl.finOk | ctl.finPf | ctl.finGp;
      pageFault <= ctl.finPf;
      gpFault   <= ctl.finGp;
      pfErr     <= ctl.finPf ? ctl.pfCode : 3'b000;
      if (ctl.finOk) begin
        frame      <= okFrame;
        pageMask   <= isLarge ? MASK_2M : MASK_4K;
        combAccess <= {pgeEnable & leafEnt[8], 5'b00000, permAnd, 1'b0};
      end else begin
        frame      <= '0;
        pageMask   <= '0;
        combAccess <= '0;
      end
    end
  end

  logic unusedBits;
  assign unusedBits = ^{linAddr[LIN_W-1:30], linAddr[11:0], BIG_W[0]};

endmodule

// File: rtl/pae_walk_ctrl.sv
module pae_walk_ctrl
  import pae_walk_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     memAck,
  input  walkSts_t sts,
  output walkCtl_t ctl,
  output logic     memReq,
  output logic     memWrite
);
  walkState_e state, nextState;
  logic execFault;

  assign execFault = sts.isFetch & (sts.nxSeen | sts.rdNx);

  always_comb begin
    nextState  = state;
    ctl        = '0;
    ctl.memSel = SEL_DIR_RD;
    memReq     = 1'b0;
    memWrite   = 1'b0;
    unique case (state)
      ST_IDLE: if (reqValid) begin
        ctl.latchReq = 1'b1;
        nextState    = ST_PTR;
      end
      ST_PTR: begin
        if (!sts.cacheOk) begin
          ctl.finGp = 1'b1;
          nextState = ST_IDLE;
        end else if (!sts.ptrPresent) begin
          ctl.finPf  = 1'b1;
          ctl.pfCode = PF_NOT_PRESENT;
          nextState  = ST_IDLE;
        end else begin
          nextState = ST_RD_DIR;
        end
      end
      ST_RD_DIR: begin
        memReq     = 1'b1;
        ctl.memSel = SEL_DIR_RD;
        if (memAck) begin
          ctl.capDir = 1'b1;
          if (!sts.rdPresent) begin
            ctl.finPf  = 1'b1;
            ctl.pfCode = PF_NOT_PRESENT;
            nextState  = ST_IDLE;
          end else if (sts.rdLarge) begin
            if (sts.rdRsvd) begin
              ctl.finPf  = 1'b1;
              ctl.pfCode = PF_RESERVED;
              nextState  = ST_IDLE;
            end else if (execFault) begin
              ctl.finPf  = 1'b1;
              ctl.pfCode = PF_EXEC;
              nextState  = ST_IDLE;
            end else begin
              nextState = ST_CHECK;
            end
          end else begin
            nextState = ST_RD_TBL;
          end
        end
      end
      ST_RD_TBL: begin
        memReq     = 1'b1;
        ctl.memSel = SEL_TBL_RD;
        if (memAck) begin
          ctl.capTbl = 1'b1;
          if (!sts.rdPresent) begin
            ctl.finPf  = 1'b1;
            ctl.pfCode = PF_NOT_PRESENT;
            nextState  = ST_IDLE;
          end else if (execFault) begin
            ctl.finPf  = 1'b1;
            ctl.pfCode = PF_EXEC;
            nextState  = ST_IDLE;
          end else begin
            nextState = ST_CHECK;
          end
        end
      end
      ST_CHECK: begin
        if (!sts.isLarge && sts.dirNeedsA) begin
          nextState = ST_WB_DIR;
        end else if (sts.leafNeedsUpd) begin
          nextState = ST_WB_LEAF;
        end else begin
          ctl.finOk = 1'b1;
          nextState = ST_IDLE;
        end
      end
      ST_WB_DIR: begin
        memReq     = 1'b1;
        memWrite   = 1'b1;
        ctl.memSel = SEL_DIR_WB;
        if (memAck) begin
          if (sts.leafNeedsUpd) begin
            nextState = ST_WB_LEAF;
          end else begin
            ctl.finOk = 1'b1;
            nextState = ST_IDLE;
          end
        end
      end
      ST_WB_LEAF: begin
        memReq     = 1'b1;
        memWrite   = 1'b1;
        ctl.memSel = SEL_LEAF_WB;
        if (memAck) begin
          ctl.finOk = 1'b1;
          nextState = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

endmodule

// File: rtl/pae_walker.sv
module pae_walker
  import pae_walk_pkg::*;
#(
  parameter int LIN_W  = 32,
  parameter int PHYS_W = 52,
  parameter int ENT_W  = 64,
  parameter int SLOTS  = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  input  logic [LIN_W-1:0]       reqLinAddr,
  input  logic [1:0]             reqAcc,
  input  logic                   ptrCacheValid,
  input  logic [SLOTS*ENT_W-1:0] ptrCache,
  input  logic                   pgeEnable,
  input  logic                   nxEnable,
  output logic                   memReq,
  output logic                   memWrite,
  output logic [PHYS_W-1:0]      memAddr,
  output logic [ENT_W-1:0]       memWdata,
  input  logic                   memAck,
  input  logic [ENT_W-1:0]       memRdata,
  output logic                   done,
  output logic                   pageFault,
  output logic                   gpFault,
  output logic [2:0]             pfErr,
  output logic [PHYS_W-13:0]     frame,
  output logic [20:0]            pageMask,
  output logic [8:0]             combAccess
);
  walkCtl_t ctl;
  walkSts_t sts;

  pae_walk_ctrl ctrlI (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .memAck(memAck),
    .sts(sts), .ctl(ctl), .memReq(memReq), .memWrite(memWrite)
  );

  pae_walk_dpath #(
    .LIN_W(LIN_W), .PHYS_W(PHYS_W), .ENT_W(ENT_W), .SLOTS(SLOTS)
  ) dpathI (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .reqLinAddr(reqLinAddr), .reqAcc(reqAcc),
    .ptrCacheValid(ptrCacheValid), .ptrCache(ptrCache),
    .pgeEnable(pgeEnable), .nxEnable(nxEnable), .memRdata(memRdata),
    .sts(sts), .memAddr(memAddr), .memWdata(memWdata),
    .done(done), .pageFault(pageFault), .gpFault(gpFault), .pfErr(pfErr),
    .frame(frame), .pageMask(pageMask), .combAccess(combAccess)
  );

endmodule

// File: rtl/pae_walker_chk.sv
module pae_walker_chk #(
  parameter int PHYS_W = 52,
  parameter int ENT_W  = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              pgeEnable,
  input logic              memReq,
  input logic              memWrite,
  input logic [PHYS_W-1:0] memAddr,
  input logic [ENT_W-1:0]  memWdata,
  input logic              memAck,
  input logic              done,
  input logic              pageFault,
  input logic              gpFault,
  input logic [2:0]        pfErr,
  input logic [20:0]       pageMask,
  input logic [8:0]        combAccess
);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R10
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWrite)));

  // R1
  fault_with_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pageFault || gpFault) |-> (done && !(pageFault && gpFault)));

  // R4
  mask_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !pageFault && !gpFault) |-> (pageMask == 21'h000FFF || pageMask == 21'h1FFFFF));

  // R5
  rsvd_prot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pageFault && pfErr[1]) |-> pfErr[0]);

  // R7
  comb_shape_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (combAccess[7:3] == 5'd0 && !combAccess[0] && (pgeEnable || !combAccess[8])));

  // R8
  wb_accessed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWrite) |-> memWdata[5]);

endmodule

bind pae_walker pae_walker_chk #(.PHYS_W(PHYS_W), .ENT_W(ENT_W)) chkI (
  .clk(clk), .rstN(rstN), .pgeEnable(pgeEnable), .memReq(memReq),
  .memWrite(memWrite), .memAddr(memAddr), .memWdata(memWdata), .memAck(memAck),
  .done(done), .pageFault(pageFault), .gpFault(gpFault), .pfErr(pfErr),
  .pageMask(pageMask), .combAccess(combAccess)
);

// File: tb/pae_walker_test.sv
module pae_walker_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 14;

  typedef struct packed {
    logic [31:0] laddr;
    logic [1:0]  acc;
    logic        nx;
    logic        pge;
    logic [63:0] dirE;
    logic [63:0] tblE;
    logic        expPf;
    logic [2:0]  expErr;
    logic        expLarge;
    logic [39:0] expFrame;
    logic [8:0]  expComb;
    logic [63:0] expDirFin;
    logic [63:0] expTblFin;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{32'h40605000, 2'd0, 1'b0, 1'b0, 64'h2007, 64'h123067, 1'b0, 3'd0, 1'b0, 40'h123, 9'h006, 64'h2027, 64'h123067},
    '{32'h40605000, 2'd1, 1'b0, 1'b0, 64'h2027, 64'h456003, 1'b0, 3'd0, 1'b0, 40'h456, 9'h002, 64'h2027, 64'h456063},
    '{32'h40605000, 2'd1, 1'b0, 1'b1, 64'h2025, 64'h789127, 1'b0, 3'd0, 1'b0, 40'h789, 9'h104, 64'h2025, 64'h789167},
    '{32'h40605000, 2'd0, 1'b0, 1'b1, 64'h600087, 64'h0, 1'b0, 3'd0, 1'b1, 40'h605, 9'h006, 64'h6000A7, 64'h0},
    '{32'h40605000, 2'd1, 1'b0, 1'b1, 64'hA001E7, 64'h0, 1'b0, 3'd0, 1'b1, 40'hA05, 9'h106, 64'hA001E7, 64'h0},
    '{32'h40605000, 2'd0, 1'b0, 1'b0, 64'h602087, 64'h0, 1'b1, 3'd3, 1'b1, 40'h0, 9'h0, 64'h602087, 64'h0},
    '{32'h40605000, 2'd0, 1'b0, 1'b0, 64'h2006, 64'h123027, 1'b1, 3'd0, 1'b0, 40'h0, 9'h0, 64'h2006, 64'h123027},
    '{32'h40605000, 2'd0, 1'b0, 1'b0, 64'h2027, 64'h456002, 1'b1, 3'd0, 1'b0, 40'h0, 9'h0, 64'h2027, 64'h456002},
    '{32'h40605000, 2'd2, 1'b1, 1'b0, 64'h8000000000002027, 64'h123007, 1'b1, 3'd5, 1'b0, 40'h0, 9'h0, 64'h8000000000002027, 64'h123007},
    '{32'h40605000, 2'd2, 1'b0, 1'b0, 64'h8000000000002027, 64'h123007, 1'b0, 3'd0, 1'b0, 40'h123, 9'h006, 64'h8000000000002027, 64'h123027},
    '{32'h40605000, 2'd0, 1'b1, 1'b0, 64'h2027, 64'h8000000000123027, 1'b0, 3'd0, 1'b0, 40'h123, 9'h006, 64'h2027, 64'h8000000000123027},
    '{32'h80605000, 2'd0, 1'b0, 1'b0, 64'h2027, 64'h321027, 1'b0, 3'd0, 1'b0, 40'h321, 9'h006, 64'h2027, 64'h321027},
    '{32'h00605000, 2'd0, 1'b0, 1'b0, 64'h2027, 64'h321027, 1'b1, 3'd0, 1'b0, 40'h0, 9'h0, 64'h2027, 64'h321027},
    '{32'h40605000, 2'd1, 1'b0, 1'b0, 64'h2067, 64'h400FFFFFFFFFF067, 1'b0, 3'd0, 1'b0, 40'hFFFFFFFFFF, 9'h006, 64'h2067, 64'h400FFFFFFFFFF067}
  };

  localparam logic [63:0] PTRS [4] = '{64'h1000, 64'h1001, 64'h3001, 64'h1001};

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         reqValid = 1'b0;
  logic [31:0]  reqLinAddr = '0;
  logic [1:0]   reqAcc = '0;
  logic         ptrCacheValid = 1'b1;
  logic [255:0] ptrCache;
  logic         pgeEnable = 1'b0;
  logic         nxEnable = 1'b0;
  logic         memReq, memWrite;
  logic [51:0]  memAddr;
  logic [63:0]  memWdata;
  logic         memAck;
  logic [63:0]  memRdata;
  logic         done, pageFault, gpFault;
  logic [2:0]   pfErr;
  logic [39:0]  frame;
  logic [20:0]  pageMask;
  logic [8:0]   combAccess;

  assign ptrCache = {PTRS[3], PTRS[2], PTRS[1], PTRS[0]};

  always #(CLK_PERIOD/2) clk = ~clk;

  pae_walker uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqLinAddr(reqLinAddr),
    .reqAcc(reqAcc), .ptrCacheValid(ptrCacheValid), .ptrCache(ptrCache),
    .pgeEnable(pgeEnable), .nxEnable(nxEnable), .memReq(memReq),
    .memWrite(memWrite), .memAddr(memAddr), .memWdata(memWdata),
    .memAck(memAck), .memRdata(memRdata), .done(done), .pageFault(pageFault),
    .gpFault(gpFault), .pfErr(pfErr), .frame(frame), .pageMask(pageMask),
    .combAccess(combAccess)
  );

  // Memory model: contents written by the stimulus only; write-backs recorded.
  logic [63:0] mem [2048];
  int          reads, writes;
  logic [51:0] wbAddr [2];
  logic [63:0] wbData [2];

  function automatic int idxOf(input logic [51:0] a);
    return int'({a[13:12], a[11:3]});
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      memAck <= 1'b0;
      memRdata <= '0;
    end else if (memReq && !memAck) begin
      memAck <= 1'b1;
      memRdata <= mem[idxOf(memAddr)];
      if (memWrite) begin
        if (writes < 2) begin
          wbAddr[writes] <= memAddr;
          wbData[writes] <= memWdata;
        end
        writes <= writes + 1;
      end else begin
        reads <= reads + 1;
      end
    end else begin
      memAck <= 1'b0;
    end
  end

  int nChecks = 0;
  int nFails  = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] finalAt(input logic [51:0] a, input logic [63:0] orig);
    logic [63:0] v = orig;
    for (int i = 0; i < 2; i++)
      if (i < writes && wbAddr[i] == a) v = wbData[i];
    return v;
  endfunction

  task automatic clearMem();
    for (int i = 0; i < 2048; i++) mem[i] = '0;
    reads = 0;
    writes = 0;
  endtask

  task automatic startWalk(input logic [31:0] la, input logic [1:0] ac);
    @(negedge clk);
    reqLinAddr = la;
    reqAcc = ac;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic waitDone(output logic ok);
    ok = 1'b0;
    for (int i = 0; i < 200; i++) begin
      if (done) begin ok = 1'b1; break; end
      @(negedge clk);
    end
    if (!ok) begin
      nChecks++;
      nFails++;
      $display("FAIL R10: actual no done expected done within 200 cycles");
    end
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    nFails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin : main
    logic ok;
    logic [51:0] dirA, tblA;
    clearMem();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // Reset state (R10)
    chk("R10 reset done", 64'(done), 64'd0);
    chk("R10 reset memReq", 64'(memReq), 64'd0);
    chk("R1 reset faults", 64'({pageFault, gpFault}), 64'd0);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      clearMem();
      dirA = {PTRS[VECS[v].laddr[31:30]][51:12], VECS[v].laddr[29:21], 3'b000};
      tblA = {VECS[v].dirE[51:12], VECS[v].laddr[20:12], 3'b000};
      mem[idxOf(dirA)] = VECS[v].dirE;
      mem[idxOf(tblA)] = VECS[v].tblE;
      nxEnable = VECS[v].nx;
      pgeEnable = VECS[v].pge;
      ptrCacheValid = 1'b1;
      startWalk(VECS[v].laddr, VECS[v].acc);
      waitDone(ok);
      if (ok) begin
        // R2 R5 R6 R9: fault indication and code
        chk($sformatf("R6 v%0d pageFault", v), 64'(pageFault), 64'(VECS[v].expPf));
        chk($sformatf("R1 v%0d gpFault", v), 64'(gpFault), 64'd0);
        if (VECS[v].expPf) begin
          chk($sformatf("R5 R9 v%0d pfErr", v), 64'(pfErr), 64'(VECS[v].expErr));
        end else begin
          chk($sformatf("R3 R4 v%0d frame", v), 64'(frame), 64'(VECS[v].expFrame));
          chk($sformatf("R4 v%0d pageMask", v), 64'(pageMask),
              VECS[v].expLarge ? 64'h1FFFFF : 64'hFFF);
          chk($sformatf("R7 v%0d combAccess", v), 64'(combAccess), 64'(VECS[v].expComb));
          if (VECS[v].expLarge)
            chk($sformatf("R4 v%0d reads", v), 64'(reads), 64'd1);
        end
        // R8: write-backs
        chk($sformatf("R8 v%0d dir entry", v), finalAt(dirA, VECS[v].dirE), VECS[v].expDirFin);
        chk($sformatf("R8 v%0d leaf entry", v), finalAt(tblA, VECS[v].tblE), VECS[v].expTblFin);
        if (VECS[v].laddr[31:30] == 2'd0)
          chk("R2 slot0 absent: reads", 64'(reads), 64'd0);
      end
      @(negedge clk);
    end

    // R1: invalid pointer cache
    clearMem();
    ptrCacheValid = 1'b0;
    startWalk(32'h40605000, 2'd0);
    waitDone(ok);
    if (ok) begin
      chk("R1 gpFault", 64'(gpFault), 64'd1);
      chk("R1 pageFault", 64'(pageFault), 64'd0);
      chk("R1 no memory access", 64'(reads + writes), 64'd0);
    end
    ptrCacheValid = 1'b1;
    @(negedge clk);

    // R10: request during a walk is ignored, done is one cycle
    clearMem();
    nxEnable = 1'b0;
    pgeEnable = 1'b0;
    mem[idxOf(52'h1018)] = 64'h2027;
    mem[idxOf(52'h2028)] = 64'h123027;
    startWalk(32'h40605000, 2'd0);
    @(negedge clk);
    reqLinAddr = 32'h00605000;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    waitDone(ok);
    if (ok) begin
      chk("R10 busy request ignored: pageFault", 64'(pageFault), 64'd0);
      chk("R10 busy request ignored: frame", 64'(frame), 64'h123);
      @(negedge clk);
      chk("R10 done single cycle", 64'(done), 64'd0);
      for (int i = 0; i < 8; i++) begin
        if (done) break;
        @(negedge clk);
      end
      chk("R10 no queued walk", 64'(done), 64'd0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule